// File: doc/BRIEF.md
# Synthesizer Frequency and Calibration Control

This block holds the 10-bit channel word for a frequency synthesizer. Software writes the word through a byte-wide register port as two parts, an upper part and a lower byte, and the block turns it into the divider ratio that the synthesizer uses. In transmit the ratio is 2048 plus the word, which is also the RF frequency in MHz. While receive is enabled the block lowers the ratio by a fixed offset of 2, so the local oscillator sits 2 MHz below the carrier. Software does not have to adjust the word when the radio changes direction.

The upper part is held in a staging register. The live word, and so the divider, changes only when the lower byte is written. The synthesizer therefore never sees a word that is half old and half new.

The block also keeps two calibration flags. A busy flag is set when a calibration starts while the synthesizer is on. A sticky done flag is set when a calibration finishes. Each time the synthesizer is switched on, the done flag is cleared. The calibration algorithm itself sits outside the block and only sends start and finish strobes.

Top module: `fsynth_ctrl`

## Requirements
- R1: After reset the live word is 0x165, the divider output is 2405, and both calibration flags are 0. A read of the low register (`reg_sel`=1) returns 0x65. A read of the high register (`reg_sel`=0) returns 0x01.
- R2: A write to the high register stores `wdata[1:0]` as the pending upper two bits of the word. The divider output and the live word do not change. A read of the high register returns the pending bits in positions [1:0].
- R3: A write to the low register makes the live word {pending upper bits, `wdata`}. The divider shows the new word one clock after the write edge.
- R4: `div_o` is registered. On each edge it loads 2048 + word when `rx_en` is 0, and 2048 + word − 2 when `rx_en` is 1.
- R5: Bits [7:2] of a high-register write are ignored. A high-register read returns calibration-done in bit 7, calibration-busy in bit 6, zero in bits [5:2] and the pending upper word bits in [1:0].
- R6: A `cal_start` pulse sets calibration-busy on the next edge, but only while `fs_on` is 1. While `fs_on` is 0 a `cal_start` pulse is ignored.
- R7: A `cal_finish` pulse sets calibration-done and clears calibration-busy on the next edge.
- R8: Calibration-done stays set until a 0-to-1 transition of `fs_on` clears it. When that transition falls in the same cycle as `cal_finish`, done ends up set.
- R9: When `cal_start` and `cal_finish` arrive in the same cycle, finish wins: busy ends up 0 and done ends up 1.
- R10: A read of the low register returns the low byte of the live word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 high control, 1 low control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| rx_en | input | 1 | Receive enable; applies the oscillator offset |
| fs_on | input | 1 | Synthesizer powered on |
| cal_start | input | 1 | Calibration start strobe |
| cal_finish | input | 1 | Calibration finish strobe |
| div_o | output | 12 | Divider ratio for the synthesizer |
| cal_done | output | 1 | Sticky calibration-done flag |
| cal_busy | output | 1 | Calibration-in-progress flag |

## Verification
Two pairs of calibration events can land in the same cycle, and the outcome of each pair is fixed by priority. In the first pair, the synthesizer power-on edge meets the finish strobe. The bench provokes it by dropping `fs_on`, then raising it in the same cycle as `cal_finish`, and it expects done to survive. In the second pair, a start strobe meets a finish strobe, and the bench expects busy to be clear and done set after that edge.

On the divider side, the bench sweeps every word value behind high-register writes whose ignored bits carry junk. It checks both receive settings, and it checks that a high-register write alone leaves the divider untouched.

// File: rtl/fsynth_pkg.sv
`timescale 1ns/1ps
package fsynth_pkg;
   // register select encoding on the byte port
   typedef enum logic {
      FS_REG_HI = 1'b0,
      FS_REG_LO = 1'b1
   } fs_reg_e;

   // calibration status pair
   typedef struct packed {
      logic done;
      logic busy;
   } fs_cal_t;
endpackage

// File: rtl/fsynth_regs.sv
`timescale 1ns/1ps
module fsynth_regs
   import fsynth_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WORD_W     = 10,
   parameter int unsigned RESET_WORD = 32'h165
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  fs_reg_e                    wr_sel,
   input  logic [DATA_W-1:0]          wdata,
   output logic [WORD_W-1:0]          word_o,
   output logic [WORD_W-DATA_W-1:0]   hi_pend_o
);
   localparam int unsigned HI_W = WORD_W - DATA_W;
   localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(RESET_WORD);

   logic [HI_W-1:0]   hi_q;
   logic [WORD_W-1:0] word_q;

   // upper bits wait in a staging register; the low-byte write commits all
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= RST_WORD[WORD_W-1:DATA_W];
         word_q <= RST_WORD;
      end else if (wr_en) begin
         if (wr_sel == FS_REG_HI) begin
            hi_q <= wdata[HI_W-1:0];
         end else begin
            word_q <= {hi_q, wdata};
         end
      end
   end

   assign word_o    = word_q;
   assign hi_pend_o = hi_q;
endmodule

// File: rtl/fsynth_div.sv
`timescale 1ns/1ps
module fsynth_div #(
   parameter int unsigned WORD_W    = 10,
   parameter int unsigned DIV_W     = 12,
   parameter int unsigned BASE_DIV  = 2048,
   parameter int unsigned RX_OFFSET = 2,
   parameter int unsigned RESET_DIV = 2405,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rx_en_i,
   output logic [DIV_W-1:0]  div_o
);
   logic [DIV_W-1:0] tx_div;
   logic [DIV_W-1:0] act_div;

   always_comb begin
      tx_div  = DIV_W'(BASE_DIV) + DIV_W'(word_i);
      act_div = tx_div - (rx_en_i ? DIV_W'(RX_OFFSET) : '0);
   end

   if (REG_OUT) begin : g_reg
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= DIV_W'(RESET_DIV);
         end else begin
            div_q <= act_div;
         end
      end
      assign div_o = div_q;
   end else begin : g_comb
      assign div_o = act_div;
   end
endmodule

// File: rtl/fsynth_cal.sv
`timescale 1ns/1ps
module fsynth_cal
   import fsynth_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fs_on_i,
   input  logic    start_i,
   input  logic    finish_i,
   output fs_cal_t stat_o
);
   logic    on_q;
   logic    on_rise;
   fs_cal_t stat_q;

   assign on_rise = fs_on_i & ~on_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         stat_q <= '0;
      end else begin
         on_q <= fs_on_i;
         // finish takes priority over the power-on clear
         if (finish_i) begin
            stat_q.done <= 1'b1;
         end else if (on_rise) begin
            stat_q.done <= 1'b0;
         end
         // finish takes priority over a coincident start
         if (finish_i) begin
            stat_q.busy <= 1'b0;
         end else if (start_i && fs_on_i) begin
            stat_q.busy <= 1'b1;
         end
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/fsynth_ctrl.sv
`timescale 1ns/1ps
module fsynth_ctrl
   import fsynth_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WORD_W     = 10,
   parameter int unsigned DIV_W      = 12,
   parameter int unsigned BASE_DIV   = 2048,
   parameter int unsigned RX_OFFSET  = 2,
   parameter int unsigned RESET_WORD = 32'h165,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              rx_en,
   input  logic              fs_on,
   input  logic              cal_start,
   input  logic              cal_finish,
   output logic [DIV_W-1:0]  div_o,
   output logic              cal_done,
   output logic              cal_busy
);
   localparam int unsigned HI_W      = WORD_W - DATA_W;
   localparam int unsigned DIV_NEED  = $clog2(BASE_DIV + (1 << WORD_W));
   localparam int unsigned RESET_DIV = BASE_DIV + (RESET_WORD % (1 << WORD_W));
   localparam int unsigned DONE_BIT  = DATA_W - 1;
   localparam int unsigned BUSY_BIT  = DATA_W - 2;

   // elaboration-time parameter checks
   if (WORD_W <= DATA_W) begin : g_bad_word
      $error("WORD_W must exceed DATA_W");
   end
   if (HI_W > DATA_W - 2) begin : g_bad_hi
      $error("upper word part collides with status bits");
   end
   if (DIV_W < DIV_NEED) begin : g_bad_div
      $error("DIV_W too narrow for BASE_DIV plus word");
   end
   if (RX_OFFSET > BASE_DIV) begin : g_bad_off
      $error("RX_OFFSET larger than BASE_DIV");
   end

   fs_reg_e            sel;
   logic [WORD_W-1:0]  word;
   logic [HI_W-1:0]    hi_pend;
   fs_cal_t            stat;

   assign sel = fs_reg_e'(reg_sel);

   fsynth_regs #(
      .DATA_W     (DATA_W),
      .WORD_W     (WORD_W),
      .RESET_WORD (RESET_WORD)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (sel),
      .wdata     (wdata),
      .word_o    (word),
      .hi_pend_o (hi_pend)
   );

   fsynth_div #(
      .WORD_W    (WORD_W),
      .DIV_W     (DIV_W),
      .BASE_DIV  (BASE_DIV),
      .RX_OFFSET (RX_OFFSET),
      .RESET_DIV (RESET_DIV),
      .REG_OUT   (REG_OUT)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (word),
      .rx_en_i (rx_en),
      .div_o   (div_o)
   );

   fsynth_cal u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs_on_i  (fs_on),
      .start_i  (cal_start),
      .finish_i (cal_finish),
      .stat_o   (stat)
   );

   // read mux: status bits on top, pending upper word bits at the bottom
   always_comb begin
      if (sel == FS_REG_LO) begin
         rdata = word[DATA_W-1:0];
      end else begin
         rdata           = '0;
         rdata[HI_W-1:0] = hi_pend;
         rdata[DONE_BIT] = stat.done;
         rdata[BUSY_BIT] = stat.busy;
      end
   end

   assign cal_done = stat.done;
   assign cal_busy = stat.busy;
endmodule

// File: rtl/fsynth_ctrl_chk.sv
`timescale 1ns/1ps
module fsynth_ctrl_chk #(
   parameter int unsigned DIV_W     = 12,
   parameter int unsigned RX_OFFSET = 2,
   parameter bit          REG_OUT   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             reg_sel,
   input logic             rx_en,
   input logic             fs_on,
   input logic             cal_start,
   input logic             cal_finish,
   input logic [DIV_W-1:0] div_o,
   input logic             cal_done,
   input logic             cal_busy
);
   logic lo_wr;
   assign lo_wr = wr_en && reg_sel;

   if (REG_OUT) begin : g_div_props
      // R2: without a low-byte commit and with rx_en steady the divider holds
      assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(lo_wr) && rx_en == $past(rx_en)) |=> $stable(div_o));

      // R4: entering receive lowers the divider by the offset
      assert_rx_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(lo_wr) && rx_en && !$past(rx_en))
         |=> div_o == $past(div_o) - DIV_W'(RX_OFFSET));
   end

   // R6: start while powered sets busy
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start && fs_on && !cal_finish) |=> cal_busy);

   // R6: start while unpowered is ignored
   assert_start_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start && !fs_on && !cal_busy && !cal_finish) |=> !cal_busy);

   // R7 and R9: finish sets done and clears busy, whatever else happens
   assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_finish |=> (cal_done && !cal_busy));

   // R8: power-on edge clears done unless finish coincides
   assert_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fs_on) && !cal_finish) |=> !cal_done);

   // R8: done never rises without a finish
   assert_done_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_done && !cal_finish) |=> !cal_done);
endmodule

bind fsynth_ctrl fsynth_ctrl_chk #(
   .DIV_W     (DIV_W),
   .RX_OFFSET (RX_OFFSET),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .reg_sel    (reg_sel),
   .rx_en      (rx_en),
   .fs_on      (fs_on),
   .cal_start  (cal_start),
   .cal_finish (cal_finish),
   .div_o      (div_o),
   .cal_done   (cal_done),
   .cal_busy   (cal_busy)
);

// File: tb/tb_fsynth_ctrl.sv
`timescale 1ns/1ps
module tb_fsynth_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rx_en = 1'b0;
   logic        fs_on = 1'b0;
   logic        cal_start = 1'b0;
   logic        cal_finish = 1'b0;
   logic [11:0] div_o;
   logic        cal_done;
   logic        cal_busy;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fsynth_ctrl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .reg_sel    (reg_sel),
      .wdata      (wdata),
      .rdata      (rdata),
      .rx_en      (rx_en),
      .fs_on      (fs_on),
      .cal_start  (cal_start),
      .cal_finish (cal_finish),
      .div_o      (div_o),
      .cal_done   (cal_done),
      .cal_busy   (cal_busy)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic sel, output int v);
      reg_sel = sel;
      #0.5;
      v = int'(rdata);
   endtask

   task automatic cal_cyc(input logic st, input logic fin, input logic on);
      @(negedge clk);
      cal_start = st; cal_finish = fin; fs_on = on;
      @(negedge clk);
      cal_start = 1'b0; cal_finish = 1'b0;
   endtask

   function automatic int hi_read(input logic done, input logic busy, input int hi);
      return (int'(done) << 7) | (int'(busy) << 6) | (hi & 3);
   endfunction

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int v;
      int exp_hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 div", int'(div_o), 2405);
      check("R1 done", int'(cal_done), 0);
      check("R1 busy", int'(cal_busy), 0);
      reg_rd(1'b1, v); check("R1 low read", v, 'h65);
      reg_rd(1'b0, v); check("R1 high read", v, 'h01);

      // R2 and R5: high write with junk upper bits stages only bits [1:0]
      reg_wr(1'b0, 8'hFE);
      @(negedge clk);
      check("R2 div held", int'(div_o), 2405);
      reg_rd(1'b0, v); check("R5 high read masks", v, 'h02);
      reg_rd(1'b1, v); check("R10 low unchanged", v, 'h65);

      // R3: low write commits {10, 00000000} = 512
      reg_wr(1'b1, 8'h00);
      @(negedge clk);
      check("R3 commit", int'(div_o), 2048 + 512);

      // R3 R4 R5 R10: sweep every word
      for (int w = 0; w < 1024; w++) begin
         logic [9:0] wv;
         wv = w[9:0];
         reg_wr(1'b0, {wv[7:2] ^ 6'h2A, wv[9:8]});
         reg_wr(1'b1, wv[7:0]);
         @(negedge clk);
         check("R3 tx div", int'(div_o), 2048 + w);
         rx_en = 1'b1;
         @(negedge clk);
         check("R4 rx div", int'(div_o), 2046 + w);
         rx_en = 1'b0;
         reg_rd(1'b1, v); check("R10 low read", v, w & 255);
         reg_rd(1'b0, v); check("R5 high read", v, hi_read(1'b0, 1'b0, w >> 8));
      end
      @(negedge clk);
      check("R4 back to tx", int'(div_o), 2048 + 1023);
      exp_hi = 3;

      // R6: start ignored while off
      cal_cyc(1'b1, 1'b0, 1'b0);
      check("R6 start ignored off", int'(cal_busy), 0);
      cal_cyc(1'b0, 1'b0, 1'b1);
      check("R8 power on done", int'(cal_done), 0);
      cal_cyc(1'b1, 1'b0, 1'b1);
      check("R6 busy set", int'(cal_busy), 1);
      reg_rd(1'b0, v); check("R5 busy bit read", v, hi_read(1'b0, 1'b1, exp_hi));

      // R7 finish
      cal_cyc(1'b0, 1'b1, 1'b1);
      check("R7 done", int'(cal_done), 1);
      check("R7 busy clear", int'(cal_busy), 0);
      reg_rd(1'b0, v); check("R5 done bit read", v, hi_read(1'b1, 1'b0, exp_hi));

      // R8 sticky, cleared by power-on edge
      cal_cyc(1'b0, 1'b0, 1'b1);
      cal_cyc(1'b0, 1'b0, 1'b1);
      check("R8 sticky", int'(cal_done), 1);
      cal_cyc(1'b0, 1'b0, 1'b0);
      check("R8 off keeps done", int'(cal_done), 1);
      cal_cyc(1'b0, 1'b0, 1'b1);
      check("R8 rise clears", int'(cal_done), 0);

      // R8: power-on edge together with finish leaves done set
      cal_cyc(1'b1, 1'b0, 1'b1);
      check("R6 busy again", int'(cal_busy), 1);
      cal_cyc(1'b0, 1'b0, 1'b0);
      cal_cyc(1'b0, 1'b1, 1'b1);
      check("R8 rise+finish done", int'(cal_done), 1);
      check("R8 rise+finish busy", int'(cal_busy), 0);

      // R9: start and finish together
      cal_cyc(1'b1, 1'b1, 1'b1);
      check("R9 busy", int'(cal_busy), 0);
      check("R9 done", int'(cal_done), 1);

      // R2 once more with flags set: high write leaves divider and flags
      reg_wr(1'b0, 8'h00);
      @(negedge clk);
      check("R2 div held late", int'(div_o), 2048 + 1023);
      reg_rd(1'b0, v); check("R5 read after stage", v, hi_read(1'b1, 1'b0, 0));

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule